// File: doc/BRIEF.md
# Interrupt Entry and Reset Sequencer

This block runs the two control sequences that a 32-bit RISC core needs outside normal instruction flow. After reset it fetches the initial program counter from memory address 0 and the initial stack pointer (R15) from address 4, then clears the status register except for its 4-bit interrupt mask, which it sets to all ones. After that it watches an external request level and, at a suitable instruction boundary, starts interrupt entry.

Interrupt entry compares the pending level with the mask field (bits 7:4) of the status register. The request is taken only when the level is strictly greater than the mask. On entry the block acknowledges the requester and reports the level. It then pushes the status register and the program counter onto the stack, with R15 decremented by one word before each push. It overwrites the mask with the accepted level and loads the program counter from the vector table at VBR + (64 + level/2) * 4. The instruction datapath holds the architectural registers. The block reads them through plain input buses and updates them through write strobes. It holds `busy` for the whole sequence and ends it with a one-cycle `done`, after which the core fetches from the new program counter.

Top module: `trap_entry_seq`

## Requirements
- R1: After reset is released, the block reads memory address 0 and then address 4, and writes the first word to the program counter and the second to R15.
- R2: The reset sequence writes the status register to 0x000000F0 (mask bits 7:4 all ones, every other bit zero), then pulses `done` once. `busy` is high from reset until that pulse.
- R3: A pending level L is ignored while L is less than or equal to the mask field SR[7:4]: no acknowledge and `busy` stays low. A level of 0 is never taken.
- R4: A pending request is taken only in a cycle where `at_boundary` is high and `in_delay_slot` is low. If it is still pending, it is taken at the first such cycle.
- R5: On acceptance, `irq_ack` is high for exactly one cycle and `irq_ack_level` carries the accepted level.
- R6: The first stack write stores the old SR at R15−4. The second stores the old PC at R15−8. R15 is written with each decremented address, so it ends at the old value minus 8.
- R7: After stacking, SR is rewritten with bits 7:4 replaced by the accepted level and all other bits unchanged.
- R8: The third memory access reads address VBR + (64 + floor(L/2)) * 4, and the word read is written to the program counter.
- R9: If `mem_ready` stays high, entry takes 13 cycles counted from the `irq_ack` cycle through the `done` cycle inclusive, and `busy` is high in exactly those 13 cycles. With stalls it takes at least 13 cycles.
- R10: While `mem_req` is high and `mem_ready` is low, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` keep their values into the next cycle. A transfer completes in a cycle where both are high, and read data is taken in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_level | input | LVL_W | Request level from the interrupt source, 0 = none |
| irq_ack | output | 1 | One-cycle acknowledge of an accepted request |
| irq_ack_level | output | LVL_W | Level being acknowledged |
| at_boundary | input | 1 | Core is between two instructions |
| in_delay_slot | input | 1 | Next instruction is a branch delay slot |
| sr_in | input | DATA_W | Current status register |
| pc_in | input | DATA_W | Current program counter (return address) |
| sp_in | input | DATA_W | Current R15 |
| vbr_in | input | DATA_W | Vector base register |
| sr_we | output | 1 | Status register write strobe |
| sr_wdata | output | DATA_W | Status register write value |
| pc_we | output | 1 | Program counter write strobe |
| pc_wdata | output | DATA_W | Program counter write value |
| sp_we | output | 1 | R15 write strobe |
| sp_wdata | output | DATA_W | R15 write value |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | DATA_W | Byte address |
| mem_wdata | output | DATA_W | Write data |
| mem_ready | input | 1 | Memory completes the access this cycle |
| mem_rdata | input | DATA_W | Read data, valid when `mem_ready` is high |
| busy | output | 1 | A reset or entry sequence is in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The bench uses the default build: a 32-bit word, a 4-bit level, a vector shift of 1 and a 13-cycle budget. With a 4-bit level every vector number from 64 to 71 can be reached, and odd and even levels share a vector, so the floor in the vector formula is visible at the memory port. Random stalls on `mem_ready` exercise the held-request rule and the stretched entry time. Random status words check that the bits outside the mask survive the mask update.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;

   typedef enum logic [3:0] {
      ST_RST_PC,
      ST_RST_SP,
      ST_RST_SR,
      ST_IDLE,
      ST_ACK,
      ST_PUSH_SR,
      ST_PUSH_PC,
      ST_SET_SR,
      ST_VEC,
      ST_PAD,
      ST_DONE
   } seq_state_e;

   // number of states from ACK through VEC plus one pad and the done cycle
   localparam int unsigned MIN_ENTRY_CYCLES = 7;

endpackage

// File: rtl/irq_level_gate.sv
module irq_level_gate #(
   parameter int unsigned LVL_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LVL_W-1:0] irq_level,
   input  logic [LVL_W-1:0] mask,
   input  logic             idle,
   input  logic             at_boundary,
   input  logic             in_delay_slot,
   output logic             take,
   output logic [LVL_W-1:0] take_level
);

   logic [LVL_W-1:0] pend_q;

   // level is retested every eligible cycle; cleared once taken
   always_ff @(posedge clk) begin
      if (!rst_n)    pend_q <= '0;
      else if (take) pend_q <= '0;
      else           pend_q <= irq_level;
   end

   assign take       = idle && at_boundary && !in_delay_slot && (pend_q > mask);
   assign take_level = pend_q;

endmodule

// File: rtl/trap_addr_gen.sv
module trap_addr_gen #(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned LVL_W     = 4,
   parameter int unsigned VEC_BASE  = 64,
   parameter int unsigned VEC_SHIFT = 1
) (
   input  logic [DATA_W-1:0] vbr,
   input  logic [DATA_W-1:0] sp,
   input  logic [LVL_W-1:0]  level,
   output logic [DATA_W-1:0] push_sr_addr,
   output logic [DATA_W-1:0] push_pc_addr,
   output logic [DATA_W-1:0] vec_addr
);

   localparam int unsigned WORD_BYTES = DATA_W / 8;
   localparam int unsigned WORD_SH    = $clog2(WORD_BYTES);

   logic [LVL_W-1:0]  vec_idx;
   logic [DATA_W-1:0] vec_num;

   generate
      if (VEC_SHIFT == 0) begin : g_vec_direct
         assign vec_idx = level;
      end else begin : g_vec_shifted
         assign vec_idx = level >> VEC_SHIFT;
      end
   endgenerate

   assign vec_num      = DATA_W'(VEC_BASE) + DATA_W'(vec_idx);
   assign vec_addr     = vbr + (vec_num << WORD_SH);
   assign push_sr_addr = sp - DATA_W'(WORD_BYTES);
   assign push_pc_addr = sp - DATA_W'(2 * WORD_BYTES);

endmodule

// File: rtl/trap_seq_fsm.sv
module trap_seq_fsm
   import trap_seq_pkg::*;
#(
   parameter int unsigned DATA_W       = 32,
   parameter int unsigned LVL_W        = 4,
   parameter int unsigned MASK_LSB     = 4,
   parameter int unsigned ENTRY_CYCLES = 13,
   parameter int unsigned RST_PC_ADDR  = 0,
   parameter int unsigned RST_SP_ADDR  = 4,
   parameter int unsigned CNT_W        = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic [LVL_W-1:0]  take_level,
   input  logic [DATA_W-1:0] sr_in,
   input  logic [DATA_W-1:0] pc_in,
   input  logic [DATA_W-1:0] sp_in,
   input  logic [DATA_W-1:0] vbr_in,
   input  logic [DATA_W-1:0] push_sr_addr,
   input  logic [DATA_W-1:0] push_pc_addr,
   input  logic [DATA_W-1:0] vec_addr,
   input  logic              mem_ready,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [LVL_W-1:0]  lvl_q,
   output logic [DATA_W-1:0] sp_q,
   output logic [DATA_W-1:0] vbr_q,
   output logic              idle,
   output logic              irq_ack,
   output logic              sr_we,
   output logic [DATA_W-1:0] sr_wdata,
   output logic              pc_we,
   output logic [DATA_W-1:0] pc_wdata,
   output logic              sp_we,
   output logic [DATA_W-1:0] sp_wdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [DATA_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              busy,
   output logic              done
);

   localparam logic [DATA_W-1:0] MASK_BITS =
      {{(DATA_W-LVL_W){1'b0}}, {LVL_W{1'b1}}} << MASK_LSB;
   localparam logic [CNT_W-1:0]  CNT_LAST  = CNT_W'(ENTRY_CYCLES - 1);

   seq_state_e        state, state_n;
   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-1:0] sr_q, pc_q, sr_new;
   logic              xfer;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_RST_PC;
         cnt   <= '0;
         lvl_q <= '0;
         sr_q  <= '0;
         pc_q  <= '0;
         sp_q  <= '0;
         vbr_q <= '0;
      end else begin
         state <= state_n;
         if (take) begin
            cnt   <= CNT_W'(1);
            lvl_q <= take_level;
            sr_q  <= sr_in;
            pc_q  <= pc_in;
            sp_q  <= sp_in;
            vbr_q <= vbr_in;
         end else if (state != ST_IDLE && cnt < CNT_LAST) begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   assign xfer = mem_req && mem_ready;

   always_comb begin
      state_n = state;
      case (state)
         ST_RST_PC:  if (xfer) state_n = ST_RST_SP;
         ST_RST_SP:  if (xfer) state_n = ST_RST_SR;
         ST_RST_SR:  state_n = ST_DONE;
         ST_IDLE:    if (take) state_n = ST_ACK;
         ST_ACK:     state_n = ST_PUSH_SR;
         ST_PUSH_SR: if (xfer) state_n = ST_PUSH_PC;
         ST_PUSH_PC: if (xfer) state_n = ST_SET_SR;
         ST_SET_SR:  state_n = ST_VEC;
         ST_VEC:     if (xfer) state_n = ST_PAD;
         ST_PAD:     if (cnt >= CNT_LAST) state_n = ST_DONE;
         ST_DONE:    state_n = ST_IDLE;
         default:    state_n = ST_IDLE;
      endcase
   end

   always_comb begin
      mem_addr  = '0;
      mem_wdata = '0;
      case (state)
         ST_RST_PC:  mem_addr = DATA_W'(RST_PC_ADDR);
         ST_RST_SP:  mem_addr = DATA_W'(RST_SP_ADDR);
         ST_PUSH_SR: begin mem_addr = push_sr_addr; mem_wdata = sr_q; end
         ST_PUSH_PC: begin mem_addr = push_pc_addr; mem_wdata = pc_q; end
         ST_VEC:     mem_addr = vec_addr;
         default:    ;
      endcase
   end

   assign mem_req = (state == ST_RST_PC) || (state == ST_RST_SP) ||
                    (state == ST_PUSH_SR) || (state == ST_PUSH_PC) ||
                    (state == ST_VEC);
   assign mem_we  = (state == ST_PUSH_SR) || (state == ST_PUSH_PC);

   assign sr_new   = (sr_q & ~MASK_BITS) |
                     ({{(DATA_W-LVL_W){1'b0}}, lvl_q} << MASK_LSB);
   assign sr_we    = (state == ST_RST_SR) || (state == ST_SET_SR);
   assign sr_wdata = (state == ST_RST_SR) ? MASK_BITS : sr_new;

   assign pc_we    = xfer && ((state == ST_RST_PC) || (state == ST_VEC));
   assign pc_wdata = mem_rdata;

   assign sp_we    = xfer && ((state == ST_RST_SP) || mem_we);
   assign sp_wdata = (state == ST_RST_SP) ? mem_rdata : mem_addr;

   assign idle    = (state == ST_IDLE);
   assign busy    = !idle;
   assign irq_ack = (state == ST_ACK);
   assign done    = (state == ST_DONE);

endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
   import trap_seq_pkg::*;
#(
   parameter int unsigned DATA_W       = 32,
   parameter int unsigned LVL_W        = 4,
   parameter int unsigned MASK_LSB     = 4,
   parameter int unsigned VEC_BASE     = 64,
   parameter int unsigned VEC_SHIFT    = 1,
   parameter int unsigned ENTRY_CYCLES = 13,
   parameter int unsigned RST_PC_ADDR  = 0,
   parameter int unsigned RST_SP_ADDR  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LVL_W-1:0]  irq_level,
   output logic              irq_ack,
   output logic [LVL_W-1:0]  irq_ack_level,
   input  logic              at_boundary,
   input  logic              in_delay_slot,
   input  logic [DATA_W-1:0] sr_in,
   input  logic [DATA_W-1:0] pc_in,
   input  logic [DATA_W-1:0] sp_in,
   input  logic [DATA_W-1:0] vbr_in,
   output logic              sr_we,
   output logic [DATA_W-1:0] sr_wdata,
   output logic              pc_we,
   output logic [DATA_W-1:0] pc_wdata,
   output logic              sp_we,
   output logic [DATA_W-1:0] sp_wdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [DATA_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ready,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              busy,
   output logic              done
);

   localparam int unsigned CNT_W = $clog2(ENTRY_CYCLES + 1);

   generate
      if (DATA_W < 16 || (DATA_W % 8) != 0 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
         $error("DATA_W must be a power of two of at least 16");
      end
      if (MASK_LSB + LVL_W > DATA_W) begin : g_bad_mask
         $error("mask field does not fit in the status word");
      end
      if (ENTRY_CYCLES < MIN_ENTRY_CYCLES) begin : g_bad_budget
         $error("ENTRY_CYCLES is below the shortest possible sequence");
      end
      if (VEC_SHIFT >= LVL_W) begin : g_bad_shift
         $error("VEC_SHIFT discards the whole level");
      end
   endgenerate

   logic              take, idle;
   logic [LVL_W-1:0]  take_level, lvl_q;
   logic [DATA_W-1:0] sp_q, vbr_q;
   logic [DATA_W-1:0] push_sr_addr, push_pc_addr, vec_addr;

   irq_level_gate #(.LVL_W(LVL_W)) u_gate (
      .clk           (clk),
      .rst_n         (rst_n),
      .irq_level     (irq_level),
      .mask          (sr_in[MASK_LSB +: LVL_W]),
      .idle          (idle),
      .at_boundary   (at_boundary),
      .in_delay_slot (in_delay_slot),
      .take          (take),
      .take_level    (take_level)
   );

   trap_addr_gen #(
      .DATA_W    (DATA_W),
      .LVL_W     (LVL_W),
      .VEC_BASE  (VEC_BASE),
      .VEC_SHIFT (VEC_SHIFT)
   ) u_addr (
      .vbr          (vbr_q),
      .sp           (sp_q),
      .level        (lvl_q),
      .push_sr_addr (push_sr_addr),
      .push_pc_addr (push_pc_addr),
      .vec_addr     (vec_addr)
   );

   trap_seq_fsm #(
      .DATA_W       (DATA_W),
      .LVL_W        (LVL_W),
      .MASK_LSB     (MASK_LSB),
      .ENTRY_CYCLES (ENTRY_CYCLES),
      .RST_PC_ADDR  (RST_PC_ADDR),
      .RST_SP_ADDR  (RST_SP_ADDR),
      .CNT_W        (CNT_W)
   ) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .take         (take),
      .take_level   (take_level),
      .sr_in        (sr_in),
      .pc_in        (pc_in),
      .sp_in        (sp_in),
      .vbr_in       (vbr_in),
      .push_sr_addr (push_sr_addr),
      .push_pc_addr (push_pc_addr),
      .vec_addr     (vec_addr),
      .mem_ready    (mem_ready),
      .mem_rdata    (mem_rdata),
      .lvl_q        (lvl_q),
      .sp_q         (sp_q),
      .vbr_q        (vbr_q),
      .idle         (idle),
      .irq_ack      (irq_ack),
      .sr_we        (sr_we),
      .sr_wdata     (sr_wdata),
      .pc_we        (pc_we),
      .pc_wdata     (pc_wdata),
      .sp_we        (sp_we),
      .sp_wdata     (sp_wdata),
      .mem_req      (mem_req),
      .mem_we       (mem_we),
      .mem_addr     (mem_addr),
      .mem_wdata    (mem_wdata),
      .busy         (busy),
      .done         (done)
   );

   assign irq_ack_level = lvl_q;

endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk #(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned LVL_W    = 4,
   parameter int unsigned MASK_LSB = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              irq_ack,
   input logic [LVL_W-1:0]  irq_ack_level,
   input logic              at_boundary,
   input logic              in_delay_slot,
   input logic [DATA_W-1:0] sr_in,
   input logic              mem_req,
   input logic              mem_we,
   input logic [DATA_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_wdata,
   input logic              mem_ready,
   input logic              busy,
   input logic              done
);

   // R3
   level_above_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack |-> (irq_ack_level > $past(sr_in[MASK_LSB +: LVL_W])));

   // R4
   eligible_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack |-> $past(at_boundary && !in_delay_slot));

   // R5
   ack_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack |=> !irq_ack);

   // R9
   done_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9
   busy_ends_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);

   // R5
   ack_starts_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack |-> busy);

   // R10
   held_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready) |=>
         (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

endmodule

bind trap_entry_seq trap_entry_chk #(
   .DATA_W   (DATA_W),
   .LVL_W    (LVL_W),
   .MASK_LSB (MASK_LSB)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .irq_ack       (irq_ack),
   .irq_ack_level (irq_ack_level),
   .at_boundary   (at_boundary),
   .in_delay_slot (in_delay_slot),
   .sr_in         (sr_in),
   .mem_req       (mem_req),
   .mem_we        (mem_we),
   .mem_addr      (mem_addr),
   .mem_wdata     (mem_wdata),
   .mem_ready     (mem_ready),
   .busy          (busy),
   .done          (done)
);

// File: tb/trap_entry_seq_test.sv
`timescale 1ns/1ps
module trap_entry_seq_test;

   localparam int DW = 32;
   localparam int LW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [LW-1:0] irq_level = '0;
   logic          irq_ack;
   logic [LW-1:0] irq_ack_level;
   logic          at_boundary = 1'b0;
   logic          in_delay_slot = 1'b0;
   logic [DW-1:0] sr_in, pc_in, sp_in, vbr_in;
   logic          sr_we, pc_we, sp_we;
   logic [DW-1:0] sr_wdata, pc_wdata, sp_wdata;
   logic          mem_req, mem_we;
   logic [DW-1:0] mem_addr, mem_wdata;
   logic          mem_ready = 1'b1;
   logic [DW-1:0] mem_rdata;
   logic          busy, done;

   always #5 clk = ~clk;

   trap_entry_seq uut (
      .clk(clk), .rst_n(rst_n), .irq_level(irq_level), .irq_ack(irq_ack),
      .irq_ack_level(irq_ack_level), .at_boundary(at_boundary),
      .in_delay_slot(in_delay_slot), .sr_in(sr_in), .pc_in(pc_in),
      .sp_in(sp_in), .vbr_in(vbr_in), .sr_we(sr_we), .sr_wdata(sr_wdata),
      .pc_we(pc_we), .pc_wdata(pc_wdata), .sp_we(sp_we), .sp_wdata(sp_wdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
      .busy(busy), .done(done)
   );

   function automatic logic [31:0] mem_word(input logic [31:0] a);
      return (a * 32'h9E37_79B1) ^ 32'h1357_2468;
   endfunction

   function automatic logic [31:0] vec_addr_of(input logic [31:0] vbr, input int lvl);
      return vbr + 32'((64 + lvl / 2) * 4);
   endfunction

   function automatic logic [31:0] sr_after(input logic [31:0] sr, input int lvl);
      return (sr & ~32'h0000_00F0) | (32'(lvl) << 4);
   endfunction

   assign mem_rdata = mem_word(mem_addr);

   // core register model
   logic          load_en = 1'b0;
   logic [DW-1:0] ld_sr = '0, ld_pc = '0, ld_sp = '0, ld_vbr = '0;
   logic [DW-1:0] sr_m = 32'hFFFF_FFFF, pc_m = '0, sp_m = '0, vbr_m = '0;
   assign sr_in = sr_m;
   assign pc_in = pc_m;
   assign sp_in = sp_m;
   assign vbr_in = vbr_m;

   always @(posedge clk) begin
      if (load_en) begin
         sr_m <= ld_sr; pc_m <= ld_pc; sp_m <= ld_sp; vbr_m <= ld_vbr;
      end else begin
         if (sr_we) sr_m <= sr_wdata;
         if (pc_we) pc_m <= pc_wdata;
         if (sp_we) sp_m <= sp_wdata;
      end
   end

   // ready generator
   logic stall_en = 1'b0;
   initial begin
      forever begin
         @(negedge clk);
         mem_ready = stall_en ? 1'($urandom % 2) : 1'b1;
      end
   end

   // monitor
   int            cyc = 0, nlog = 0, n_ack = 0, n_done = 0, busy_cnt = 0;
   int            ack_cyc = 0, done_cyc = 0, ack_lvl = 0;
   int            mon_chk = 0, mon_err = 0;
   logic [31:0]   lg_addr [0:511];
   logic [31:0]   lg_data [0:511];
   logic          lg_we   [0:511];
   logic          p_stall = 1'b0, p_we = 1'b0;
   logic [31:0]   p_addr = '0, p_data = '0;

   always @(negedge clk) begin
      cyc <= cyc + 1;
      if (rst_n) begin
         if (p_stall) begin
            mon_chk <= mon_chk + 1;
            if (!(mem_req && mem_addr == p_addr && mem_we == p_we && mem_wdata == p_data)) begin
               mon_err <= mon_err + 1;
               $display("FAIL R10 held request actual=%h expected=%h", mem_addr, p_addr);
            end
         end
         if (mem_req && mem_ready) begin
            lg_addr[nlog % 512] <= mem_addr;
            lg_data[nlog % 512] <= mem_wdata;
            lg_we[nlog % 512]   <= mem_we;
            nlog <= nlog + 1;
         end
         if (irq_ack) begin n_ack <= n_ack + 1; ack_cyc <= cyc; ack_lvl <= int'(irq_ack_level); end
         if (done) begin n_done <= n_done + 1; done_cyc <= cyc; end
         if (busy) busy_cnt <= busy_cnt + 1;
      end
      p_stall <= rst_n && mem_req && !mem_ready;
      p_addr  <= mem_addr;
      p_we    <= mem_we;
      p_data  <= mem_wdata;
   end

   int n_chk = 0, n_err = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic load_regs(input logic [31:0] sr, pc, sp, vbr);
      @(negedge clk);
      ld_sr = sr; ld_pc = pc; ld_sp = sp; ld_vbr = vbr; load_en = 1'b1;
      @(negedge clk);
      load_en = 1'b0;
   endtask

   task automatic wait_done(input int nd);
      int t = 0;
      while (n_done == nd && t < 400) begin @(negedge clk); t++; end
   endtask

   task automatic verify_entry(input int base, input int b_busy, input logic [31:0] sr0, pc0, sp0, vbr0,
                               input int lvl, input bit stall);
      logic [31:0] va;
      int          span;
      va   = vec_addr_of(vbr0, lvl);
      span = done_cyc - ack_cyc + 1;
      chk(ack_lvl == lvl, "R5 ack level", 32'(ack_lvl), 32'(lvl));
      chk(nlog - base == 3, "R6 access count", 32'(nlog - base), 32'd3);
      chk(lg_we[base % 512] && lg_addr[base % 512] == sp0 - 4 && lg_data[base % 512] == sr0,
          "R6 SR push", lg_data[base % 512], sr0);
      chk(lg_we[(base+1) % 512] && lg_addr[(base+1) % 512] == sp0 - 8 && lg_data[(base+1) % 512] == pc0,
          "R6 PC push", lg_data[(base+1) % 512], pc0);
      chk(sp_m == sp0 - 8, "R6 final R15", sp_m, sp0 - 8);
      chk(!lg_we[(base+2) % 512] && lg_addr[(base+2) % 512] == va, "R8 vector address",
          lg_addr[(base+2) % 512], va);
      chk(pc_m == mem_word(va), "R8 new PC", pc_m, mem_word(va));
      chk(sr_m == sr_after(sr0, lvl), "R7 new SR", sr_m, sr_after(sr0, lvl));
      if (!stall) begin
         chk(span == 13, "R9 entry cycles", 32'(span), 32'd13);
         chk(busy_cnt - b_busy == 13, "R9 busy cycles", 32'(busy_cnt - b_busy), 32'd13);
      end else begin
         chk(span >= 13, "R9 stalled entry cycles", 32'(span), 32'd13);
      end
   endtask

   task automatic run_case(input logic [31:0] sr0, pc0, sp0, vbr0, input int lvl, input bit stall);
      int base, b_busy, na, nd, t;
      load_regs(sr0, pc0, sp0, vbr0);
      stall_en = stall;
      base = nlog; b_busy = busy_cnt; na = n_ack; nd = n_done;
      irq_level = LW'(lvl); at_boundary = 1'b1; in_delay_slot = 1'b0;
      if (lvl <= int'(sr0[7:4])) begin
         repeat (12) @(negedge clk);
         chk(n_ack == na, "R3 masked level ignored", 32'(n_ack - na), 32'd0);
         chk(busy_cnt == b_busy, "R3 busy stays low", 32'(busy_cnt - b_busy), 32'd0);
         irq_level = '0;
      end else begin
         t = 0;
         while (n_ack == na && t < 50) begin @(negedge clk); t++; end
         irq_level = '0;
         wait_done(nd);
         verify_entry(base, b_busy, sr0, pc0, sp0, vbr0, lvl, stall);
      end
      stall_en = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic summary(input int extra);
      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors",
                  n_chk + mon_chk + extra, n_err + mon_err + extra);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      summary(1);
   end

   initial begin
      int base, b_busy, na, nd, t, lvl;
      logic [31:0] sr0, sp0, vbr0, pc0;
      void'($urandom(32'd2024));

      // reset
      repeat (5) @(negedge clk);
      chk(busy == 1'b1, "R2 busy in reset", 32'(busy), 32'd1);
      rst_n = 1'b1;
      wait_done(0);
      repeat (5) @(negedge clk);
      chk(!lg_we[0] && lg_addr[0] == 32'd0, "R1 first read at 0", lg_addr[0], 32'd0);
      chk(!lg_we[1] && lg_addr[1] == 32'd4, "R1 second read at 4", lg_addr[1], 32'd4);
      chk(pc_m == mem_word(32'd0), "R1 reset PC", pc_m, mem_word(32'd0));
      chk(sp_m == mem_word(32'd4), "R1 reset R15", sp_m, mem_word(32'd4));
      chk(sr_m == 32'h0000_00F0, "R2 reset SR", sr_m, 32'h0000_00F0);
      chk(n_done == 1, "R2 single done", 32'(n_done), 32'd1);
      chk(busy == 1'b0, "R2 idle after reset", 32'(busy), 32'd0);

      // R3 directed: equal level and level 0
      run_case(32'h0000_0370, 32'h0600_0100, 32'h0600_4000, 32'h0600_0000, 7, 0);
      run_case(32'h0000_0000, 32'h0600_0100, 32'h0600_4000, 32'h0600_0000, 0, 0);
      // corner vectors: lowest and highest
      run_case(32'h0000_0000, 32'h0600_0200, 32'h0600_4000, 32'h0600_0000, 1, 0);
      run_case(32'h0000_03E3, 32'h0600_0300, 32'h0600_8000, 32'h0200_0000, 15, 0);

      // R4 directed: delay slot and no boundary block acceptance
      load_regs(32'h0000_0031, 32'h0600_0400, 32'h0600_2000, 32'h0400_0000);
      base = nlog; b_busy = busy_cnt; na = n_ack; nd = n_done;
      irq_level = 4'd9; at_boundary = 1'b1; in_delay_slot = 1'b1;
      repeat (10) @(negedge clk);
      chk(n_ack == na, "R4 no entry in delay slot", 32'(n_ack - na), 32'd0);
      at_boundary = 1'b0; in_delay_slot = 1'b0;
      repeat (10) @(negedge clk);
      chk(n_ack == na, "R4 no entry off boundary", 32'(n_ack - na), 32'd0);
      at_boundary = 1'b1;
      t = 0;
      while (n_ack == na && t < 10) begin @(negedge clk); t++; end
      chk(t <= 2, "R4 taken at first eligible cycle", 32'(t), 32'd2);
      irq_level = '0;
      wait_done(nd);
      verify_entry(base, b_busy, 32'h0000_0031, 32'h0600_0400, 32'h0600_2000, 32'h0400_0000, 9, 0);
      repeat (3) @(negedge clk);

      // random cases
      for (int i = 0; i < 40; i++) begin
         sr0  = $urandom & 32'h0000_03F3;
         pc0  = $urandom & ~32'h1;
         sp0  = $urandom & ~32'h3;
         vbr0 = $urandom & ~32'h3;
         lvl  = 1 + int'($urandom % 15);
         run_case(sr0, pc0, sp0, vbr0, lvl, 1'($urandom % 2));
      end

      summary(0);
   end

endmodule